// File: doc/BRIEF.md
# Serial Transmitter with Idle Preamble and Pin Handover

This block serializes characters onto a single output line. A one-entry holding register takes a character from a register write and passes it to a shift register. The shift register sends it as an asynchronous frame: a low start bit, then the data bits with the least significant bit first, then a high stop bit. Each bit lasts exactly one pulse of the externally supplied baud tick. A mode bit selects 8 or 9 data bits. A transmission session starts when the enable bit rises. The first thing sent is an idle character: a full frame time of high level with no start or stop bit. A break request sends a frame time of low level.

The block claims the line while enabled. When the enable bit is cleared, it keeps the line until all queued work has drained: the character in the shift register, a held character, and one requested break. Only then does it hand the line back. If the block is re-enabled while that last character is still going out, it keeps the line and queues a new idle preamble. Two flags report progress. One says the holding register is empty. The other says the transmitter is completely idle. Each flag can raise the shared interrupt request through its own enable.

Top module: `uart_tx_preamble`

## Requirements
- R1: After reset, `txd` is 1, `pin_own` is 0, `flag_empty` is 1, `flag_done` is 1, and all control bits are 0.
- R2: A frame is a 0 start bit, then the data bits with bit 0 first, then a 1 stop bit. Each bit is held for one `baud_tick`. With `ctrl_nine`=0 the frame carries `data_in[7:0]`, lasts 10 bit times, and ignores `data_in[8]`. With `ctrl_nine`=1 it carries all 9 bits and lasts 11 bit times. The line changes only on a tick.
- R3: A control write that raises the enable bit from 0 to 1 sets `pin_own` on the next clock. At the next tick the block starts an idle preamble of all ones. The preamble lasts 10 or 11 ticks, following `ctrl_nine`, and is sent before any held character.
- R4: A character written while a frame is in flight starts at the tick that ends the current frame, with no gap between frames. `flag_empty` is set at the tick that moves the held character into the shift register. A data write clears both `flag_empty` and `flag_done`.
- R5: `flag_done` is set only at a tick where a frame ends and nothing else is loaded and the holding register is empty. It stays 0 while a preamble, a break or a data frame is being sent.
- R6: While the break bit is set and the block owns the line, each free tick loads a break. A break is 10 or 11 low bit times, following `ctrl_nine`, followed by one high bit.
- R7: Clearing the enable bit does not release the line at once. The shift register, any held character and one pending break are all sent first. At the tick after the last one ends, `pin_own` falls. A break that loads while the block is disabled clears the break bit, so it is sent only once.
- R8: If the enable bit goes 0 and then back to 1 while the last character is being sent, `pin_own` stays 1. A fresh idle preamble follows that character, and `flag_done` stays 0 until the preamble ends.
- R9: `irq` equals (`flag_empty` AND the empty-interrupt enable) OR (`flag_done` AND the done-interrupt enable).
- R10: While the line is released (`pin_own`=0), `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| ctrl_we | input | 1 | Writes all control bits below |
| ctrl_en | input | 1 | Transmitter enable |
| ctrl_brk | input | 1 | Break request |
| ctrl_nine | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| ctrl_ie_empty | input | 1 | Interrupt enable for the holding-empty flag |
| ctrl_ie_done | input | 1 | Interrupt enable for the idle flag |
| data_we | input | 1 | Writes `data_in` into the holding register |
| data_in | input | 9 | Character to send |
| txd | output | 1 | Serial output |
| pin_own | output | 1 | 1 while the transmitter owns the line |
| flag_empty | output | 1 | Holding register is empty |
| flag_done | output | 1 | Shift and holding stages empty, no break or idle in progress |
| irq | output | 1 | Masked interrupt request |

## Verification
The embedded assertions check rules that hold on every cycle. The shift register does not move between ticks. A frame starts only on a tick. The line is never released while enabled or between ticks. The idle flag never coexists with a busy shifter or a full holding register. The order of events can only be shown by the bench's scenarios: the preamble before queued data, the exact bit sequence of each frame width, break followed by a stop-level bit, the drain before release, and the preamble queued by a quick re-enable. The bench follows these bit by bit at the serial pin.

// File: rtl/uart_tx_preamble.sv
module uart_tx_preamble (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       ctrl_we,
  input  logic       ctrl_en,
  input  logic       ctrl_brk,
  input  logic       ctrl_nine,
  input  logic       ctrl_ie_empty,
  input  logic       ctrl_ie_done,
  input  logic       data_we,
  input  logic [8:0] data_in,
  output logic       txd,
  output logic       pin_own,
  output logic       flag_empty,
  output logic       flag_done,
  output logic       irq
);
  localparam int SW = 12;
  localparam int CW = 4;

  logic          en_r, brk_r, nine_r, iee_r, ied_r;
  logic          empty_r, done_r, own_r, busy_r, pre_r;
  logic [8:0]    hold_r;
  logic [SW-1:0] sh_r;
  logic [CW-1:0] cnt_r;

  logic          free, step, ld_pre, ld_brk, ld_dat, ld_any;
  logic [CW-1:0] len;
  logic [SW-1:0] frame_dat, frame_brk;

  assign free      = !busy_r || (cnt_r == CW'(1));
  assign step      = baud_tick && free;
  assign ld_pre    = step && pre_r && en_r;
  assign ld_brk    = step && !ld_pre && brk_r && own_r;
  assign ld_dat    = step && !ld_pre && !ld_brk && !empty_r && own_r;
  assign ld_any    = ld_pre || ld_brk || ld_dat;
  assign len       = nine_r ? CW'(11) : CW'(10);
  assign frame_dat = nine_r ? {2'b11, hold_r, 1'b0} : {3'b111, hold_r[7:0], 1'b0};
  assign frame_brk = nine_r ? SW'(12'h800) : SW'(12'hC00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_r    <= 1'b0;
      brk_r   <= 1'b0;
      nine_r  <= 1'b0;
      iee_r   <= 1'b0;
      ied_r   <= 1'b0;
      empty_r <= 1'b1;
      done_r  <= 1'b1;
      own_r   <= 1'b0;
      busy_r  <= 1'b0;
      pre_r   <= 1'b0;
      hold_r  <= '0;
      sh_r    <= '1;
      cnt_r   <= '0;
    end else begin
      if (baud_tick && busy_r) begin
        sh_r  <= {1'b1, sh_r[SW-1:1]};
        cnt_r <= cnt_r - CW'(1);
      end
      if (step) begin
        busy_r <= ld_any;
        done_r <= !ld_any && empty_r;
        if (!ld_any && !en_r) own_r <= 1'b0;
      end
      if (ld_pre) begin
        sh_r  <= '1;
        cnt_r <= len;
        pre_r <= 1'b0;
      end
      if (ld_brk) begin
        sh_r  <= frame_brk;
        cnt_r <= len + CW'(1);
        if (!en_r) brk_r <= 1'b0;
      end
      if (ld_dat) begin
        sh_r    <= frame_dat;
        cnt_r   <= len;
        empty_r <= 1'b1;
      end
      if (data_we) begin
        hold_r  <= data_in;
        empty_r <= 1'b0;
        done_r  <= 1'b0;
      end
      if (ctrl_we) begin
        en_r   <= ctrl_en;
        brk_r  <= ctrl_brk;
        nine_r <= ctrl_nine;
        iee_r  <= ctrl_ie_empty;
        ied_r  <= ctrl_ie_done;
        pre_r  <= ctrl_en && (pre_r || !en_r);
        if (ctrl_en) own_r <= 1'b1;
      end
    end
  end

  assign txd        = (own_r && busy_r) ? sh_r[0] : 1'b1;
  assign pin_own    = own_r;
  assign flag_empty = empty_r;
  assign flag_done  = done_r;
  assign irq        = (empty_r && iee_r) || (done_r && ied_r);

  // R3
  en_holds_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_r |-> own_r);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_r |-> (!busy_r && empty_r));

  // R2
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_r && !baud_tick) |=> ($stable(sh_r) && $stable(cnt_r)));

  // R4
  start_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_r) |-> $past(baud_tick));

  // R7
  release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(own_r) |-> ($past(baud_tick) && !$past(en_r)));
endmodule

// File: tb/tb_uart_tx_preamble.sv
module tb_uart_tx_preamble;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0;
  logic ctrl_we = 1'b0, ctrl_en = 1'b0, ctrl_brk = 1'b0, ctrl_nine = 1'b0;
  logic ctrl_ie_empty = 1'b0, ctrl_ie_done = 1'b0;
  logic data_we = 1'b0;
  logic [8:0] data_in = '0;
  logic txd, pin_own, flag_empty, flag_done, irq;
  int checks = 0;
  int errors = 0;

  // bit 9 = mode (1 = nine bits), bits 8:0 = character
  localparam logic [9:0] VEC [6] = '{10'h0A5, 10'h1C3, 10'h3C3, 10'h22D, 10'h0FF, 10'h000};

  always #2 clk = ~clk;

  uart_tx_preamble dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .ctrl_we(ctrl_we), .ctrl_en(ctrl_en), .ctrl_brk(ctrl_brk), .ctrl_nine(ctrl_nine),
    .ctrl_ie_empty(ctrl_ie_empty), .ctrl_ie_done(ctrl_ie_done),
    .data_we(data_we), .data_in(data_in),
    .txd(txd), .pin_own(pin_own), .flag_empty(flag_empty), .flag_done(flag_done), .irq(irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) baud_tick = 1'b1;
    @(negedge clk) baud_tick = 1'b0;
  endtask

  task automatic ctrl(input logic en, input logic brk, input logic nine, input logic iee, input logic ied);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_en = en; ctrl_brk = brk; ctrl_nine = nine;
    ctrl_ie_empty = iee; ctrl_ie_done = ied;
    @(negedge clk) ctrl_we = 1'b0;
  endtask

  task automatic wdat(input logic [8:0] d);
    @(negedge clk);
    data_we = 1'b1; data_in = d;
    @(negedge clk) data_we = 1'b0;
  endtask

  function automatic logic fbit(input logic nine, input logic [8:0] d, input int i);
    int n = nine ? 11 : 10;
    if (i == 0) return 1'b0;
    if (i == n - 1) return 1'b1;
    return d[i-1];
  endfunction

  task automatic frame_bits(input logic nine, input logic [8:0] d, input int lo, input int hi, input string req);
    for (int i = lo; i < hi; i++) begin
      tick();
      chk(req, $sformatf("txd bit %0d of %0h", i, d), txd, fbit(nine, d, i));
      chk("R7", "pin_own during frame", pin_own, 1);
      chk("R5", "flag_done during frame", flag_done, 0);
    end
  endtask

  task automatic level_ticks(input int n, input logic lvl, input string req);
    for (int i = 0; i < n; i++) begin
      tick();
      chk(req, $sformatf("line level tick %0d", i), txd, lvl);
      chk(req, "pin_own", pin_own, 1);
      chk("R5", "flag_done while generating", flag_done, 0);
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "txd", txd, 1);
    chk("R1", "pin_own", pin_own, 0);
    chk("R1", "flag_empty", flag_empty, 1);
    chk("R1", "flag_done", flag_done, 1);
    chk("R9", "irq masked", irq, 0);
    tick();
    chk("R10", "released txd", txd, 1);
    chk("R10", "released pin_own", pin_own, 0);

    // R3 enable, preamble before held data; vector walk for R2/R4
    ctrl(1, 0, 0, 1, 1);
    chk("R3", "pin_own after enable", pin_own, 1);
    chk("R9", "irq from empty", irq, 1);
    wdat(VEC[0][8:0]);
    chk("R4", "empty cleared by write", flag_empty, 0);
    chk("R4", "done cleared by write", flag_done, 0);
    chk("R9", "irq both flags low", irq, 0);
    level_ticks(10, 1'b1, "R3");
    chk("R3", "data still held after preamble", flag_empty, 0);
    for (int k = 0; k < 6; k++) begin
      if (k > 0) begin
        ctrl(1, 0, VEC[k][9], 1, 1);
        wdat(VEC[k][8:0]);
      end
      frame_bits(VEC[k][9], VEC[k][8:0], 0, 1, "R2");
      chk("R4", "empty set at load", flag_empty, 1);
      chk("R9", "irq on empty", irq, 1);
      frame_bits(VEC[k][9], VEC[k][8:0], 1, VEC[k][9] ? 11 : 10, "R2");
    end
    tick();
    chk("R5", "done after last frame", flag_done, 1);
    chk("R2", "line idle high", txd, 1);
    chk("R9", "irq on done", irq, 1);

    // R7 release at tick, R3 nine-bit preamble length
    ctrl(0, 0, 1, 1, 1);
    chk("R7", "pin kept until tick", pin_own, 1);
    tick();
    chk("R7", "pin released at tick", pin_own, 0);
    chk("R10", "released line high", txd, 1);
    ctrl(1, 0, 1, 0, 0);
    chk("R9", "irq masked with flags set", irq, 0);
    wdat(9'h155);
    level_ticks(11, 1'b1, "R3");
    frame_bits(1, 9'h155, 0, 11, "R2");
    tick();
    chk("R5", "done after nine-bit frame", flag_done, 1);

    // R6 break
    ctrl(1, 1, 0, 0, 0);
    level_ticks(10, 1'b0, "R6");
    ctrl(1, 0, 0, 0, 0);
    tick();
    chk("R6", "stop-level bit after break", txd, 1);
    chk("R5", "done during break tail", flag_done, 0);
    tick();
    chk("R5", "done after break", flag_done, 1);

    // R7 disable drains shift and held character
    wdat(9'h0F0);
    frame_bits(0, 9'h0F0, 0, 1, "R2");
    wdat(9'h033);
    ctrl(0, 0, 0, 0, 0);
    frame_bits(0, 9'h0F0, 1, 10, "R7");
    frame_bits(0, 9'h033, 0, 10, "R7");
    tick();
    chk("R7", "released after drain", pin_own, 0);
    chk("R10", "line high after release", txd, 1);

    // R8 re-enable during last character
    ctrl(1, 0, 0, 0, 0);
    wdat(9'h081);
    level_ticks(10, 1'b1, "R3");
    frame_bits(0, 9'h081, 0, 1, "R2");
    ctrl(0, 0, 0, 0, 0);
    ctrl(1, 0, 0, 0, 0);
    frame_bits(0, 9'h081, 1, 10, "R8");
    level_ticks(10, 1'b1, "R8");
    tick();
    chk("R8", "pin kept after queued preamble", pin_own, 1);
    chk("R8", "done after queued preamble", flag_done, 1);

    // R7 break requested while disabled is sent once, then release
    wdat(9'h03C);
    frame_bits(0, 9'h03C, 0, 1, "R2");
    ctrl(0, 1, 0, 0, 0);
    frame_bits(0, 9'h03C, 1, 10, "R7");
    level_ticks(10, 1'b0, "R7");
    tick();
    chk("R6", "stop-level bit after drained break", txd, 1);
    chk("R7", "pin held through break tail", pin_own, 1);
    tick();
    chk("R7", "released after single break", pin_own, 0);
    tick();
    chk("R7", "no repeated break", txd, 1);
    chk("R10", "stays released", pin_own, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule